// File: doc/BRIEF.md
# Exclusive Prefetch Queue Filter

This block sits on the cache side of a core's store path. A store-access request is an early notice that a store to an address is coming. The request arrives together with the result of the cache's permission lookup for that line. If the line is already present and writable, the request is absorbed and produces nothing. In every other case, the block builds a hardware prefetch request for the whole line that asks for exclusive permission. It then places that request in a bounded queue.

Each queued entry carries its line-aligned address and a ready timestamp. An entry is offered to the miss-request path only after its ready time has passed, and only while the miss queue reports room. A ready/valid handshake removes the entry. When the queue is full, the oldest entry is discarded to make room for the new one, and a drop counter is incremented.

Completions coming back from memory are routed by kind. An exclusive prefetch fill marks its line as hardware-prefetched and sends nothing to the processor. A store-access completion produces a retry pulse that wakes stalled store senders. Normal completions are forwarded as processor responses.

Top module: `epq_filter`

## Requirements
- R1: A request with `sa_hit_i`=1 and `sa_writable_i`=1 is absorbed. It enqueues nothing and never changes `drop_cnt_o`, even when the queue is full.
- R2: A request that misses (`sa_hit_i`=0), or that hits without write permission (`sa_hit_i`=1, `sa_writable_i`=0), enqueues exactly one exclusive prefetch entry.
- R3: The offered address `pf_addr_o` is the request address with its low log2(LINE_BYTES) bits cleared. `pf_size_o` always equals LINE_BYTES.
- R4: A request that is enqueued while the queue holds DEPTH entries, with no pop in the same cycle, discards the oldest entry and increments `drop_cnt_o` by one. The remaining entries keep their order.
- R5: An entry captured at clock edge E into an empty queue raises `pf_valid_o` for the first time right after the PF_LAT-th rising edge following E.
- R6: While `mshr_full_i`=1, `pf_valid_o` is 0.
- R7: An entry leaves the queue only on a cycle with `pf_valid_o`=1 and `pf_ready_i`=1. Entries leave in arrival order.
- R8: A completion with `cmp_kind_i`=1 (exclusive prefetch fill) gives a one-cycle `mark_pf_o` pulse one cycle later, with `mark_addr_o` set to `cmp_addr_i`. It produces no `cpu_resp_o`.
- R9: A completion with `cmp_kind_i`=2 (store-access done) gives a one-cycle `retry_o` pulse one cycle later. It produces no `cpu_resp_o`.
- R10: A completion with `cmp_kind_i`=0 gives a one-cycle `cpu_resp_o` pulse one cycle later. A completion with `cmp_kind_i`=3 produces no output pulse. At most one of `mark_pf_o`, `retry_o` and `cpu_resp_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sa_valid_i | input | 1 | Store-access request present |
| sa_addr_i | input | AW | Store-access byte address |
| sa_hit_i | input | 1 | Lookup found the line |
| sa_writable_i | input | 1 | Found line holds write permission |
| mshr_full_i | input | 1 | Miss queue has no free slot |
| pf_valid_o | output | 1 | Head prefetch is eligible and offered |
| pf_ready_i | input | 1 | Miss path accepts the offered prefetch |
| pf_addr_o | output | AW | Line-aligned prefetch address |
| pf_size_o | output | $clog2(LINE_BYTES)+1 | Prefetch size in bytes |
| drop_cnt_o | output | CW | Entries discarded because the queue was full |
| cmp_valid_i | input | 1 | Completion present |
| cmp_kind_i | input | 2 | 0 normal, 1 prefetch fill, 2 store-access done, 3 reserved |
| cmp_addr_i | input | AW | Completion line address |
| mark_pf_o | output | 1 | Mark filled line as hardware-prefetched |
| mark_addr_o | output | AW | Line to mark |
| retry_o | output | 1 | Wake stalled store senders |
| cpu_resp_o | output | 1 | Response forwarded to the processor side |

## Verification
The bench builds the block with DEPTH=4, LINE_BYTES=16, AW=16 and PF_LAT=3. The small depth means a few back-to-back requests are enough to reach the overflow and drop-oldest path. The short latency makes it cheap to count the exact edge on which an entry becomes eligible. With a 16-byte line, a sweep of spread-out addresses crossed with all four hit/writable combinations covers both filtering and alignment. All four completion kinds are also driven.

// File: rtl/epq_pkg.sv
package epq_pkg;
  typedef enum logic [1:0] {
    CMP_NORMAL  = 2'd0,
    CMP_PF_FILL = 2'd1,
    CMP_SA_DONE = 2'd2,
    CMP_RSVD    = 2'd3
  } cmp_kind_e;
endpackage

// File: rtl/epq_classify.sv
module epq_classify #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          hit_i,
  input  logic          writable_i,
  output logic          push_o,
  output logic [AW-1:0] line_addr_o
);
  localparam logic [AW-1:0] OFS_MASK = AW'(LINE_BYTES - 1);

  // writable hit needs no work
  assign push_o      = req_valid_i && !(hit_i && writable_i);
  assign line_addr_o = req_addr_i & ~OFS_MASK;
endmodule

// File: rtl/epq_fifo.sv
module epq_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [TW-1:0] push_rdy_i,
  input  logic          pop_i,
  output logic          head_valid_o,
  output logic [AW-1:0] head_addr_o,
  output logic [TW-1:0] head_rdy_o,
  output logic          drop_o
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [AW-1:0]  addr_q [DEPTH];
  logic [TW-1:0]  rdy_q  [DEPTH];
  logic [PW-1:0]  hd_q, tl_q;
  logic [CNW-1:0] cnt_q;
  logic           full, empty, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt_q == CNW'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign do_pop = pop_i && !empty;
  assign drop_o = push_i && full && !do_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop || drop_o) hd_q <= nxt(hd_q);
      if (push_i)           tl_q <= nxt(tl_q);
      if (push_i && !do_pop && !full) cnt_q <= cnt_q + 1'b1;
      else if (!push_i && do_pop)     cnt_q <= cnt_q - 1'b1;
    end
  end

  // when full, tail aliases head, which is leaving this cycle
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tl_q] <= push_addr_i;
      rdy_q[tl_q]  <= push_rdy_i;
    end
  end

  assign head_valid_o = !empty;
  assign head_addr_o  = addr_q[hd_q];
  assign head_rdy_o   = rdy_q[hd_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNW'(DEPTH)); // R4
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> cnt_q == CNW'(DEPTH)); // R4
endmodule

// File: rtl/epq_cmp_route.sv
module epq_cmp_route #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmp_valid_i,
  input  logic [1:0]    cmp_kind_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic          mark_pf_o,
  output logic [AW-1:0] mark_addr_o,
  output logic          retry_o,
  output logic          cpu_resp_o
);
  import epq_pkg::*;

  cmp_kind_e kind;
  assign kind = cmp_kind_e'(cmp_kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_pf_o   <= 1'b0;
      mark_addr_o <= '0;
      retry_o     <= 1'b0;
      cpu_resp_o  <= 1'b0;
    end else begin
      mark_pf_o  <= cmp_valid_i && (kind == CMP_PF_FILL);
      retry_o    <= cmp_valid_i && (kind == CMP_SA_DONE);
      cpu_resp_o <= cmp_valid_i && (kind == CMP_NORMAL);
      if (cmp_valid_i && kind == CMP_PF_FILL) mark_addr_o <= cmp_addr_i;
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mark_pf_o, retry_o, cpu_resp_o})); // R10
  AST_RETRY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && kind == CMP_SA_DONE) |=> retry_o && !cpu_resp_o); // R9
  AST_MARK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && kind == CMP_PF_FILL) |=> mark_pf_o && mark_addr_o == $past(cmp_addr_i)); // R8
endmodule

// File: rtl/epq_filter.sv
module epq_filter #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 8,
  parameter int PF_LAT     = 4,
  parameter int TW         = 16,
  parameter int CW         = 16,
  localparam int SW        = $clog2(LINE_BYTES) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sa_valid_i,
  input  logic [AW-1:0] sa_addr_i,
  input  logic          sa_hit_i,
  input  logic          sa_writable_i,
  input  logic          mshr_full_i,
  output logic          pf_valid_o,
  input  logic          pf_ready_i,
  output logic [AW-1:0] pf_addr_o,
  output logic [SW-1:0] pf_size_o,
  output logic [CW-1:0] drop_cnt_o,
  input  logic          cmp_valid_i,
  input  logic [1:0]    cmp_kind_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic          mark_pf_o,
  output logic [AW-1:0] mark_addr_o,
  output logic          retry_o,
  output logic          cpu_resp_o
);
  localparam logic [TW-1:0] STAMP_OFS = TW'(PF_LAT + 1);
  localparam logic [AW-1:0] OFS_MASK  = AW'(LINE_BYTES - 1);

  logic [TW-1:0] now_q, head_rdy, age;
  logic [AW-1:0] line_addr, head_addr;
  logic          push, head_valid, drop, eligible;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  epq_classify #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_cls (
    .req_valid_i (sa_valid_i),
    .req_addr_i  (sa_addr_i),
    .hit_i       (sa_hit_i),
    .writable_i  (sa_writable_i),
    .push_o      (push),
    .line_addr_o (line_addr)
  );

  epq_fifo #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_addr_i  (line_addr),
    .push_rdy_i   (now_q + STAMP_OFS),
    .pop_i        (pf_valid_o && pf_ready_i),
    .head_valid_o (head_valid),
    .head_addr_o  (head_addr),
    .head_rdy_o   (head_rdy),
    .drop_o       (drop)
  );

  // wrap-safe "now >= ready"
  assign age        = now_q - head_rdy;
  assign eligible   = head_valid && !age[TW-1];
  assign pf_valid_o = eligible && !mshr_full_i;
  assign pf_addr_o  = head_addr;
  assign pf_size_o  = SW'(LINE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   drop_cnt_o <= '0;
    else if (drop) drop_cnt_o <= drop_cnt_o + 1'b1;
  end

  epq_cmp_route #(.AW(AW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmp_valid_i (cmp_valid_i),
    .cmp_kind_i  (cmp_kind_i),
    .cmp_addr_i  (cmp_addr_i),
    .mark_pf_o   (mark_pf_o),
    .mark_addr_o (mark_addr_o),
    .retry_o     (retry_o),
    .cpu_resp_o  (cpu_resp_o)
  );

  AST_MSHR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mshr_full_i |-> !pf_valid_o); // R6
  AST_PF_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (pf_addr_o & OFS_MASK) == '0); // R3
  AST_ABSORB_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sa_valid_i && sa_hit_i && sa_writable_i) |=> $stable(drop_cnt_o)); // R1
endmodule

// File: tb/sim_epq_filter.sv
module sim_epq_filter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, LB = 16, DEPTH = 4, LAT = 3, CW = 16;
  localparam int SW = $clog2(LB) + 1;

  logic clk = 0, rst_n = 0;
  logic sa_valid = 0, sa_hit = 0, sa_wr = 0, mshr_full = 0, pf_ready = 0;
  logic [AW-1:0] sa_addr = '0, cmp_addr = '0;
  logic cmp_valid = 0;
  logic [1:0] cmp_kind = '0;
  logic pf_valid, mark_pf, retry, cpu_resp;
  logic [AW-1:0] pf_addr, mark_addr;
  logic [SW-1:0] pf_size;
  logic [CW-1:0] drop_cnt;

  int n_chk = 0, n_fail = 0, exp_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epq_filter #(.AW(AW), .LINE_BYTES(LB), .DEPTH(DEPTH), .PF_LAT(LAT), .TW(16), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sa_valid_i(sa_valid), .sa_addr_i(sa_addr),
    .sa_hit_i(sa_hit), .sa_writable_i(sa_wr), .mshr_full_i(mshr_full),
    .pf_valid_o(pf_valid), .pf_ready_i(pf_ready), .pf_addr_o(pf_addr), .pf_size_o(pf_size),
    .drop_cnt_o(drop_cnt), .cmp_valid_i(cmp_valid), .cmp_kind_i(cmp_kind), .cmp_addr_i(cmp_addr),
    .mark_pf_o(mark_pf), .mark_addr_o(mark_addr), .retry_o(retry), .cpu_resp_o(cpu_resp));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int a, input bit h, input bit w);
    @(negedge clk);
    sa_valid = 1; sa_addr = AW'(a); sa_hit = h; sa_wr = w;
    @(negedge clk);
    sa_valid = 0;
  endtask

  task automatic drain(input int exp_a, input string req);
    int waited = 0;
    while (!pf_valid && waited < 50) begin @(negedge clk); waited++; end
    chk(pf_valid, req, "pf_valid before pop", int'(pf_valid), 1);
    chk(pf_addr == AW'(exp_a), req, "pf_addr", int'(pf_addr), exp_a);
    chk(pf_size == SW'(LB), "R3", "pf_size", int'(pf_size), LB);
    pf_ready = 1;
    @(negedge clk);
    pf_ready = 0;
  endtask

  task automatic idle_check(input int cycles, input string req);
    bit seen = 0;
    for (int k = 0; k < cycles; k++) begin @(negedge clk); if (pf_valid) seen = 1; end
    chk(!seen, req, "pf_valid while expected empty", int'(seen), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pf_valid && drop_cnt == 0 && !retry && !mark_pf && !cpu_resp, "R7", "reset outputs",
        int'(pf_valid) + int'(drop_cnt), 0);
    rst_n = 1;
    @(negedge clk);

    // R5: eligibility edge count
    push(16'h1234, 0, 0);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      chk(pf_valid == (k == LAT), "R5", $sformatf("pf_valid after edge %0d", k), int'(pf_valid), int'(k == LAT));
    end
    // R7: no removal without ready
    repeat (5) @(negedge clk);
    chk(pf_valid && pf_addr == 16'h1230, "R7", "held until accepted", int'(pf_addr), 16'h1230);
    drain(16'h1230, "R3");
    idle_check(LAT + 2, "R7");

    // R1: writable hit absorbed
    push(16'h0400, 1, 1);
    idle_check(LAT + 4, "R1");

    // R6: miss queue full blocks
    mshr_full = 1;
    push(16'h0ABF, 1, 0);
    idle_check(LAT + 4, "R6");
    @(negedge clk); mshr_full = 0; #1;
    chk(pf_valid, "R6", "pf_valid after release", int'(pf_valid), 1);
    drain(16'h0AB0, "R2");

    // R4: overflow drops oldest
    for (int i = 0; i < DEPTH + 2; i++) push(i * 16'h0100 + 3, 0, 0);
    exp_drop += 2;
    chk(drop_cnt == CW'(exp_drop), "R4", "drop_cnt", int'(drop_cnt), exp_drop);
    // R1 when full: no drop
    push(16'h7777, 1, 1);
    chk(drop_cnt == CW'(exp_drop), "R1", "drop_cnt after absorbed on full", int'(drop_cnt), exp_drop);
    for (int i = 2; i < DEPTH + 2; i++) drain(i * 16'h0100, "R4");
    idle_check(LAT + 2, "R4");

    // R2/R3 sweep
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 4; j++) begin
        int a = (i * 1237 + 5) & 16'hFFFF;
        bit h = j[0], w = j[1];
        push(a, h, w);
        if (h && w) idle_check(LAT + 1, "R1");
        else drain(a & ~(LB - 1), "R2");
      end
    end
    chk(drop_cnt == CW'(exp_drop), "R4", "no drops during sweep", int'(drop_cnt), exp_drop);

    // R8-R10 completion routing
    for (int kd = 0; kd < 4; kd++) begin
      @(negedge clk);
      cmp_valid = 1; cmp_kind = 2'(kd); cmp_addr = AW'(16'h5000 + kd * 16'h40);
      @(negedge clk);
      cmp_valid = 0;
      chk(mark_pf == (kd == 1), "R8", $sformatf("mark_pf kind %0d", kd), int'(mark_pf), int'(kd == 1));
      chk(retry == (kd == 2), "R9", $sformatf("retry kind %0d", kd), int'(retry), int'(kd == 2));
      chk(cpu_resp == (kd == 0), "R10", $sformatf("cpu_resp kind %0d", kd), int'(cpu_resp), int'(kd == 0));
      if (kd == 1) chk(mark_addr == 16'h5040, "R8", "mark_addr", int'(mark_addr), 16'h5040);
      @(negedge clk);
      chk(!mark_pf && !retry && !cpu_resp, "R10", "pulse width one", int'(mark_pf | retry | cpu_resp), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule